// File: doc/BRIEF.md
# GPIO Edge Interrupt Cause Unit

This block watches a bank of up to 32 general-purpose input pins and turns selected transitions into one interrupt request. Each pin passes through a synchroniser. Software arms each pin separately for rising transitions, falling transitions, or both. A detected transition sets that pin's bit in a sticky cause vector. A separate event-enable mask selects which cause bits reach the interrupt output.

The interrupt output is a plain level signal, so it can be wired-OR'd with the requests of other banks. An interrupt handler reads the pending word, which is the cause vector already ANDed with the mask. It then acknowledges by writing that same word to the clear offset, which is write-one-to-clear. Only edge-triggered sensing is provided. The block does not drive pins.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, the rise-enable, fall-enable, event-enable and cause vectors are all zero, every readable offset returns 0, and `irq_o` is low.
- R2: The rise-enable vector is read and written at offset 0x44. When bit n of this vector is 1, a 0-to-1 transition of `pin_i[n]` sets cause bit n.
- R3: The fall-enable vector is read and written at offset 0x48. When bit n of this vector is 1, a 1-to-0 transition of `pin_i[n]` sets cause bit n.
- R4: A pin whose rise-enable and fall-enable bits are both 1 sets its cause bit on either transition.
- R5: A pin transition whose direction is not enabled leaves the cause bit unchanged.
- R6: A cause bit is set on an enabled transition even while its event-enable bit is 0. The bit becomes visible in the pending word as soon as the mask bit is later set.
- R7: The event-enable mask is read and written at offset 0x94. A read of offset 0x80 returns the cause vector ANDed with this mask.
- R8: A write to offset 0x98 clears every cause bit whose data bit is 1 and leaves every cause bit whose data bit is 0 unchanged.
- R9: When an enabled transition and a clear of the same bit occur in the same cycle, the cause bit is 1 after that cycle.
- R10: `irq_o` is the OR of the pending bits. After a pin change applied between clock edges, `irq_o` is still low after two rising clock edges and is high after the third, provided the transition is enabled and its mask bit is set.
- R11: Reads of offset 0x98 and of any unmapped offset return 0. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPINS | Asynchronous pin levels |
| wr_en_i | input | 1 | Register write strobe, sampled on the clock edge |
| addr_i | input | 8 | Register byte offset, used for both reads and writes |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that the pins are held low while reset is asserted. Under that assumption, the synchroniser does not report a transition left over from reset. The assertions also assume that `wr_en_i` and `addr_i` change only between clock edges. The stimulus follows both rules: it drives every input on the falling clock edge and keeps all pins at 0 until reset is released. Random pin flips are mixed with random register writes, including acknowledge writes of the current pending word. This lets clears meet fresh transitions.

// File: rtl/gei_pkg.sv
package gei_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_RISE = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_FALL = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_PEND = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h94;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h98;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RISE,
    SEL_FALL,
    SEL_PEND,
    SEL_MASK,
    SEL_CLR
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_RISE: decode_ofs = SEL_RISE;
      OFS_FALL: decode_ofs = SEL_FALL;
      OFS_PEND: decode_ofs = SEL_PEND;
      OFS_MASK: decode_ofs = SEL_MASK;
      OFS_CLR:  decode_ofs = SEL_CLR;
      default:  decode_ofs = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gei_sync.sv
module gei_sync #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] cur_o,
  output logic [NPINS-1:0] prev_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [DEPTH-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[DEPTH-2:0], pin_i[p]};
    end
    assign cur_o[p]  = chain_q[DEPTH-2];
    assign prev_o[p] = chain_q[DEPTH-1];
  end

  // R10: the delayed copy follows the synchronised value one cycle later
  a_r10_prev_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (prev_o == $past(cur_o)));
endmodule

// File: rtl/gei_regs.sv
module gei_regs
  import gei_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NPINS-1:0]  cause_i,
  output logic [NPINS-1:0]  rise_en_o,
  output logic [NPINS-1:0]  fall_en_o,
  output logic [NPINS-1:0]  mask_o,
  output logic [NPINS-1:0]  clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e         sel;
  logic [NPINS-1:0] wbits;
  logic [NPINS-1:0] pend;

  assign sel   = decode_ofs(addr_i);
  assign wbits = wdata_i[NPINS-1:0];
  assign pend  = cause_i & mask_o;
  assign clr_o = (wr_en_i && sel == SEL_CLR) ? wbits : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_en_o <= '0;
      fall_en_o <= '0;
      mask_o    <= '0;
    end else if (wr_en_i) begin
      if (sel == SEL_RISE) rise_en_o <= wbits;
      if (sel == SEL_FALL) fall_en_o <= wbits;
      if (sel == SEL_MASK) mask_o    <= wbits;
    end
  end

  always_comb begin
    case (sel)
      SEL_RISE: rdata_o = DATA_W'(rise_en_o);
      SEL_FALL: rdata_o = DATA_W'(fall_en_o);
      SEL_PEND: rdata_o = DATA_W'(pend);
      SEL_MASK: rdata_o = DATA_W'(mask_o);
      default:  rdata_o = '0;
    endcase
  end

  a_r11_unmapped_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel == SEL_NONE) |=> ($stable(rise_en_o) && $stable(fall_en_o) && $stable(mask_o)));

  a_r11_clr_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_CLR || sel == SEL_NONE) |-> (rdata_o == '0));
endmodule

// File: rtl/gei_cause.sv
module gei_cause #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] cur_i,
  input  logic [NPINS-1:0] prev_i,
  input  logic [NPINS-1:0] rise_en_i,
  input  logic [NPINS-1:0] fall_en_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] set_o,
  output logic [NPINS-1:0] cause_o
);
  function automatic logic [NPINS-1:0] edge_hits(
    input logic [NPINS-1:0] cur, input logic [NPINS-1:0] prev,
    input logic [NPINS-1:0] ren, input logic [NPINS-1:0] fen);
    edge_hits = (cur & ~prev & ren) | (~cur & prev & fen);
  endfunction

  function automatic logic [NPINS-1:0] cause_next(
    input logic [NPINS-1:0] held, input logic [NPINS-1:0] clr,
    input logic [NPINS-1:0] hits);
    cause_next = (held & ~clr) | hits;  // a fresh hit overrides a clear
  endfunction

  assign set_o = edge_hits(cur_i, prev_i, rise_en_i, fall_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_o <= '0;
    else         cause_o <= cause_next(cause_o, clr_i, set_o);
  end

  a_r9_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(set_o) & ~cause_o) == '0));

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(cause_o) & ~$past(clr_i) & ~cause_o) == '0));

  a_r5_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cause_o & ~$past(cause_o) & ~$past(set_o)) == '0));

  a_r2_r3_direction: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_o & ~rise_en_i & ~fall_en_i) == '0) && ((set_o & (cur_i ^ ~prev_i)) == '0));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gei_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [NPINS-1:0] pin_cur, pin_prev;
  logic [NPINS-1:0] rise_en, fall_en, mask, clr_vec;
  logic [NPINS-1:0] set_vec, cause_q;

  gei_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .cur_o  (pin_cur),
    .prev_o (pin_prev)
  );

  gei_regs #(.NPINS(NPINS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .cause_i   (cause_q),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en),
    .mask_o    (mask),
    .clr_o     (clr_vec),
    .rdata_o   (rdata_o)
  );

  gei_cause #(.NPINS(NPINS)) u_cause (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cur_i     (pin_cur),
    .prev_i    (pin_prev),
    .rise_en_i (rise_en),
    .fall_en_i (fall_en),
    .clr_i     (clr_vec),
    .set_o     (set_vec),
    .cause_o   (cause_q)
  );

  assign irq_o = |(cause_q & mask);

  a_r7_mask_silences: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o);

  a_r10_irq_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ((|$past(set_vec)) || ($past(mask) != mask)));

  a_r6_irq_fall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> ((|$past(clr_vec)) || ($past(mask) != mask)));
endmodule

// File: tb/gpio_edge_irq_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_irq_tb_top;
  localparam int NP = 32;
  localparam logic [7:0] A_RISE = 8'h44, A_FALL = 8'h48, A_PEND = 8'h80,
                         A_MASK = 8'h94, A_CLR = 8'h98;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [NP-1:0] pins  = '0;
  logic          wr_en = 1'b0;
  logic [7:0]    addr  = A_PEND;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  gpio_edge_irq #(.NPINS(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // Reference state derived from the requirements: three-edge pin latency,
  // edge-over-clear priority, write-one-to-clear.
  logic [NP-1:0] m_rise, m_fall, m_mask, m_cause, m_s1, m_s2, m_s3;

  function automatic logic [NP-1:0] ref_hits(input logic [NP-1:0] now_v,
      input logic [NP-1:0] old_v, input logic [NP-1:0] r, input logic [NP-1:0] f);
    logic [NP-1:0] up = now_v & ~old_v;
    logic [NP-1:0] dn = old_v & ~now_v;
    return (up & r) | (dn & f);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rise <= '0; m_fall <= '0; m_mask <= '0; m_cause <= '0;
      m_s1 <= '0; m_s2 <= '0; m_s3 <= '0;
    end else begin
      m_s1 <= pins; m_s2 <= m_s1; m_s3 <= m_s2;
      m_cause <= ref_hits(m_s2, m_s3, m_rise, m_fall) |
                 (m_cause & ~((wr_en && addr == A_CLR) ? wdata : 32'h0));
      if (wr_en) begin
        if (addr == A_RISE) m_rise <= wdata;
        if (addr == A_FALL) m_fall <= wdata;
        if (addr == A_MASK) m_mask <= wdata;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = A_PEND;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] v;

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_RISE, v); chk("R1 rise", v, 0);
    rd(A_FALL, v); chk("R1 fall", v, 0);
    rd(A_MASK, v); chk("R1 mask", v, 0);
    rd(A_PEND, v); chk("R1 pend", v, 0);
    chk("R1 irq", {31'h0, irq}, 0);

    // R2 / R10: rising edge and its exact latency
    wr(A_RISE, 32'h8); wr(A_MASK, 32'h8);
    rd(A_RISE, v); chk("R2 rise readback", v, 32'h8);
    pins[3] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R10 irq low after two edges", {31'h0, irq}, 0);
    @(negedge clk);
    chk("R10 irq high after three edges", {31'h0, irq}, 1);
    rd(A_PEND, v); chk("R2 rise sets cause", v, 32'h8);
    wr(A_CLR, 32'h8);
    rd(A_PEND, v); chk("R8 clear pending", v, 0);
    chk("R8 irq drops", {31'h0, irq}, 0);

    // R5 / R3: pin 5 fall-only
    wr(A_FALL, 32'h20); wr(A_MASK, 32'h28);
    rd(A_FALL, v); chk("R3 fall readback", v, 32'h20);
    pins[5] = 1'b1; idle(5);
    rd(A_PEND, v); chk("R5 rise not enabled", v, 0);
    pins[5] = 1'b0; idle(5);
    rd(A_PEND, v); chk("R3 fall sets cause", v, 32'h20);
    wr(A_CLR, 32'h20);

    // R4: both directions on pin 7
    wr(A_RISE, 32'h88); wr(A_FALL, 32'hA0); wr(A_MASK, 32'hA8);
    pins[7] = 1'b1; idle(5);
    rd(A_PEND, v); chk("R4 rise", v, 32'h80);
    wr(A_CLR, 32'h80);
    rd(A_PEND, v); chk("R4 cleared", v, 0);
    pins[7] = 1'b0; idle(5);
    rd(A_PEND, v); chk("R4 fall", v, 32'h80);

    // R6: pin 9 latches while masked
    wr(A_RISE, 32'h288);
    pins[9] = 1'b1; idle(5);
    rd(A_PEND, v); chk("R6 masked hidden", v, 32'h80);
    wr(A_MASK, 32'h2A8);
    rd(A_MASK, v); chk("R7 mask readback", v, 32'h2A8);
    rd(A_PEND, v); chk("R6 unmask reveals", v, 32'h280);
    chk("R10 irq", {31'h0, irq}, 1);

    // R8 partial clear
    wr(A_CLR, 32'h200);
    rd(A_PEND, v); chk("R8 partial clear", v, 32'h80);
    wr(A_CLR, 32'h80);

    // R9: edge and clear collide on pin 11
    wr(A_RISE, 32'hA88); wr(A_FALL, 32'hAA0); wr(A_MASK, 32'hAA8);
    pins[11] = 1'b1; idle(5);
    rd(A_PEND, v); chk("R9 setup", v, 32'h800);
    @(negedge clk); pins[11] = 1'b0;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    wr_en = 1'b1; addr = A_CLR; wdata = 32'h800;
    @(negedge clk); wr_en = 1'b0;
    rd(A_PEND, v); chk("R9 edge wins", v, 32'h800);
    wr(A_CLR, 32'h800);
    rd(A_PEND, v); chk("R9 plain clear", v, 0);

    // R11 unmapped and write-only offsets
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h84, 32'hFFFF_FFFF);
    rd(A_RISE, v); chk("R11 rise kept", v, 32'hA88);
    rd(A_FALL, v); chk("R11 fall kept", v, 32'hAA0);
    rd(A_MASK, v); chk("R11 mask kept", v, 32'hAA8);
    rd(A_CLR, v);  chk("R11 clr reads 0", v, 0);
    rd(8'h20, v);  chk("R11 unmapped reads 0", v, 0);

    // Random phase against the reference state
    for (int i = 0; i < 4000; i++) begin
      int r;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R10 irq random", {31'h0, irq}, {31'h0, |(m_cause & m_mask)});
      r = int'($urandom % 8);
      if (r < 3) pins[$urandom % NP] ^= 1'b1;
      if (r >= 5) begin
        int k = int'($urandom % 5);
        wr_en = 1'b1;
        wdata = $urandom;
        case (k)
          0: addr = A_RISE;
          1: addr = A_FALL;
          2: addr = A_MASK;
          3: begin addr = A_CLR; wdata = m_cause & m_mask; end
          default: addr = A_CLR;
        endcase
      end else begin
        rd(A_PEND, v); chk("R7 pending random", v, m_cause & m_mask);
      end
    end
    @(negedge clk); wr_en = 1'b0;
    rd(A_RISE, v); chk("R2 final rise", v, m_rise);
    rd(A_FALL, v); chk("R3 final fall", v, m_fall);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule